// File: doc/BRIEF.md
# Quadrature IF-to-Baseband Downmixer

This block converts a one-bit sampled intermediate-frequency stream to complex baseband in two mixing steps. The first step uses a tunable numerically controlled oscillator (NCO) to perform a quadrature (single-sideband) mix. Because each input sample is one bit, this mix needs no multiplier: the NCO cosine and sine are passed through or negated. The second step is a fixed rotation at a quarter of the sample rate. It moves the remaining 2.048 MHz tone (sampled at 8.192 MHz) to zero frequency by swapping I and Q and negating them, and it needs no multiplier either.

The IF image appears at 2.508 MHz after sampling. The NCO runs at a nominal 460 kHz and leaves the signal at 2.048 MHz. An external frequency-tracking loop trims the NCO by supplying a signed correction word, which is added to the nominal tuning word. The correction is latched at a sample strobe and is used from the following strobe on. Downstream low-pass filtering is not part of this block.

Top module: `if_downmix`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `bb_valid` is 0 and `bb_i`/`bb_q` are 0. The NCO phase restarts at 0.
- R2: `bb_valid` is high for exactly the one cycle that follows each cycle in which `smp_en` is high. In every other cycle it is low.
- R3: The phase accumulator is 24 bits wide. With zero correction it advances by round(460000/8192000 × 2^24) = 942080 at each strobe. It wraps modulo 2^24.
- R4: An input bit of 1 counts as +1 and an input bit of 0 counts as −1.
- R5: Let p be the top 6 bits of the phase before the strobe's advance. Let S(p) = round(127·sin(2πp/64)) and C(p) = round(127·cos(2πp/64)), both 8-bit signed. The first mix gives I1 = s·C(p) and Q1 = −s·S(p), where s is the sign from R4.
- R6: The n-th sample since reset (n from 0) is rotated by (−j)^(n mod 4). The outputs are (I1,Q1), (Q1,−I1), (−I1,−Q1) and (−Q1,I1) for n mod 4 = 0, 1, 2 and 3.
- R7: `freq_corr` (20-bit signed) is captured at each strobe. The advance made at the next strobe is 942080 plus the captured value, sign-extended to 24 bits. The value of `freq_corr` between strobes has no effect.
- R8: Between strobes, `bb_i`, `bb_q` and the phase hold their values.
- R9: Phase wraparound, including advances shortened by negative corrections, gives outputs that follow R5 using the wrapped phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe, one cycle per input sample |
| smp_bit | input | 1 | One-bit IF sample (1 = +1, 0 = −1) |
| freq_corr | input | 20 | Signed correction added to the nominal NCO increment |
| bb_i | output | 8 | Signed in-phase baseband sample |
| bb_q | output | 8 | Signed quadrature baseband sample |
| bb_valid | output | 1 | High for one cycle when a new I/Q pair is presented |

## Verification
The bench builds the block with its defaults: a 24-bit accumulator, a 20-bit correction, and 8.192 MHz and 460 kHz as the sample and NOM frequencies. With these values the nominal step is 942080, so the phase wraps after about 18 strobes. A few dozen samples therefore pass through every quadrant of the table, every rotation phase and several wraps. Corrections near the 20-bit limits (±524287) shorten or lengthen the step by more than half. This makes the one-strobe delay of the correction and the wraparound arithmetic easy to see in the output values.

// File: rtl/if_downmix.sv
`timescale 1ns/1ps
module if_downmix #(
  parameter int ACC_W  = 24,
  parameter int CORR_W = 20,
  parameter longint FS_HZ = 8192000,
  parameter longint LO_HZ = 460000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              smp_bit,
  input  logic [CORR_W-1:0] freq_corr,
  output logic [7:0]        bb_i,
  output logic [7:0]        bb_q,
  output logic              bb_valid
);
  // Table geometry is fixed by the quarter-wave contents below: 6-bit address, 8-bit amplitude.
  localparam int LUT_AW = 6;
  localparam longint NOM_WIDE = ((LO_HZ << ACC_W) + FS_HZ / 2) / FS_HZ;
  localparam logic [ACC_W-1:0] NOM_INC = NOM_WIDE[ACC_W-1:0];

  logic [ACC_W-1:0]  phase;
  logic [CORR_W-1:0] corr_hold;
  logic [1:0]        rot;

  function automatic logic [6:0] qsin(input logic [4:0] k);
    case (k)
      5'd0:  qsin = 7'd0;   5'd1:  qsin = 7'd12;  5'd2:  qsin = 7'd25;
      5'd3:  qsin = 7'd37;  5'd4:  qsin = 7'd49;  5'd5:  qsin = 7'd60;
      5'd6:  qsin = 7'd71;  5'd7:  qsin = 7'd81;  5'd8:  qsin = 7'd90;
      5'd9:  qsin = 7'd98;  5'd10: qsin = 7'd106; 5'd11: qsin = 7'd112;
      5'd12: qsin = 7'd117; 5'd13: qsin = 7'd122; 5'd14: qsin = 7'd125;
      5'd15: qsin = 7'd126; default: qsin = 7'd127;
    endcase
  endfunction

  function automatic logic [7:0] wave(input logic [LUT_AW-1:0] p);
    logic [4:0] idx;
    logic [7:0] mag;
    idx  = p[4] ? (5'd16 - {1'b0, p[3:0]}) : {1'b0, p[3:0]};
    mag  = {1'b0, qsin(idx)};
    wave = p[5] ? (8'd0 - mag) : mag;
  endfunction

  wire [LUT_AW-1:0] addr = phase[ACC_W-1 -: LUT_AW];
  wire [7:0] sin_v = wave(addr);
  wire [7:0] cos_v = wave(addr + LUT_AW'(16));
  wire [7:0] mix_i = smp_bit ? cos_v : 8'd0 - cos_v;
  wire [7:0] mix_q = smp_bit ? 8'd0 - sin_v : sin_v;
  wire [ACC_W-1:0] corr_ext = {{(ACC_W-CORR_W){corr_hold[CORR_W-1]}}, corr_hold};

  logic [7:0] rot_i, rot_q;
  always_comb begin
    case (rot)
      2'd0:    begin rot_i = mix_i;          rot_q = mix_q;          end
      2'd1:    begin rot_i = mix_q;          rot_q = 8'd0 - mix_i;   end
      2'd2:    begin rot_i = 8'd0 - mix_i;   rot_q = 8'd0 - mix_q;   end
      default: begin rot_i = 8'd0 - mix_q;   rot_q = mix_i;          end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      corr_hold <= '0;
      rot       <= '0;
      bb_i      <= '0;
      bb_q      <= '0;
      bb_valid  <= 1'b0;
    end else begin
      bb_valid <= smp_en;
      if (smp_en) begin
        phase     <= phase + NOM_INC + corr_ext;
        corr_hold <= freq_corr;
        rot       <= rot + 2'd1;
        bb_i      <= rot_i;
        bb_q      <= rot_q;
      end
    end
  end
endmodule

module if_downmix_chk #(parameter int ACC_W = 24) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_en,
  input logic             bb_valid,
  input logic [7:0]       bb_i,
  input logic [7:0]       bb_q,
  input logic [1:0]       rot,
  input logic [ACC_W-1:0] phase
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) smp_en |=> bb_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> !bb_valid); // R2
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> ($stable(bb_i) && $stable(bb_q))); // R8
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> $stable(phase)); // R8
  AST_ROT_STEP: assert property (@(posedge clk) disable iff (!rst_n) smp_en |=> rot == $past(rot) + 2'd1); // R6
  AST_NO_FULL_SCALE_NEG: assert property (@(posedge clk) disable iff (!rst_n) bb_valid |-> (bb_i != 8'h80 && bb_q != 8'h80)); // R5
endmodule

bind if_downmix if_downmix_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .bb_valid(bb_valid),
  .bb_i(bb_i), .bb_q(bb_q), .rot(rot), .phase(phase)
);

// File: tb/if_downmix_tb.sv
`timescale 1ns/1ps
module if_downmix_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic smp_bit = 1'b0;
  logic [19:0] freq_corr = '0;
  logic [7:0] bb_i, bb_q;
  logic bb_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  longint m_phase;
  longint m_hold;
  int     m_n;

  always #5 clk = ~clk;

  if_downmix dut_i (.clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_bit(smp_bit),
                    .freq_corr(freq_corr), .bb_i(bb_i), .bb_q(bb_q), .bb_valid(bb_valid));

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_hold = 0; m_n = 0;
  endtask

  // One strobe: drive, then compare against the model one cycle later.
  task automatic sample(input bit b, input int corr, input string req);
    int p, sv, cv, s, i1, q1, ei, eq;
    real ang;
    p   = int'(m_phase >> 18) & 63;
    ang = 2.0 * 3.14159265358979 * real'(p) / 64.0;
    sv  = rnd(127.0 * $sin(ang));
    cv  = rnd(127.0 * $cos(ang));
    s   = b ? 1 : -1;
    i1  = s * cv;
    q1  = -s * sv;
    case (m_n % 4)
      0: begin ei = i1;  eq = q1;  end
      1: begin ei = q1;  eq = -i1; end
      2: begin ei = -i1; eq = -q1; end
      default: begin ei = -q1; eq = i1; end
    endcase
    @(negedge clk);
    smp_en = 1'b1; smp_bit = b; freq_corr = 20'(corr);
    @(negedge clk);
    smp_en = 1'b0;
    check({req, " valid"}, int'(bb_valid), 1);
    check({req, " I"}, int'($signed(bb_i)), ei);
    check({req, " Q"}, int'($signed(bb_q)), eq);
    m_phase = (m_phase + 942080 + m_hold) & 64'hFFFFFF;
    m_hold  = longint'(corr);
    m_n++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(bb_valid), 0);
    check("R1 I in reset", int'(bb_i), 0);
    check("R1 Q in reset", int'(bb_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(bb_valid), 0);
    model_reset();
  endtask

  task automatic t_plain();
    for (int k = 0; k < 24; k++) sample(k[0], 0, "R3/R5/R6 nominal");
    for (int k = 0; k < 8; k++)  sample(1'b1, 0, "R4 ones");
    for (int k = 0; k < 8; k++)  sample(1'b0, 0, "R4 zeros");
  endtask

  task automatic t_gap();
    logic [7:0] hi, hq;
    sample(1'b1, 0, "R2 before gap");
    hi = bb_i; hq = bb_q;
    repeat (5) @(negedge clk);
    check("R2 no valid in gap", int'(bb_valid), 0);
    check("R8 I held", int'(bb_i), int'(hi));
    check("R8 Q held", int'(bb_q), int'(hq));
    sample(1'b0, 0, "R8 phase held across gap");
  endtask

  task automatic t_corr();
    sample(1'b1, 300000, "R7 latch positive");
    @(negedge clk); freq_corr = 20'h7FFFF;
    @(negedge clk); freq_corr = 20'h80000;
    sample(1'b1, -200000, "R7 delayed effect");
    sample(1'b0, 123457, "R7 second step");
    sample(1'b1, 0, "R7 after change");
    sample(1'b1, 0, "R7 settled");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 30; k++) sample(k[1], -524288, "R9 short step wrap");
    for (int k = 0; k < 30; k++) sample(~k[0], 524287, "R9 long step wrap");
  endtask

  initial begin
    model_reset();
    t_reset();
    t_plain();
    t_gap();
    t_corr();
    t_wrap();
    t_reset();
    sample(1'b1, 0, "R1 phase restart");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule